// File: doc/BRIEF.md
# Dual-Role Byte Serial Port

This block moves one byte at a time over a four-wire synchronous serial link. It can act as master or slave, chosen by the `isMaster` input. In master mode it makes the serial clock and the active-low select itself. In slave mode it takes both from outside and passes them through two-flop synchronisers. A single shift register sends and receives at once. A write loads that register directly, so the transmit side has no holding stage. A received byte is copied into a separate read buffer, so the host can read it while the next byte is shifting in.

The host side is a plain register port. `wrEn`/`wrData` load the outgoing byte, and in master mode that write also starts the transfer. `rdData` always shows the read buffer, and a pulse on `rdEn` acknowledges it. Status comes out on four flags: `busy`, `rxFull`, `overrun` and `wcol`. The two data pins change roles with the mode: pin A is the master's output and the slave's input, and pin B is the reverse.

Top module: `spi_duplex_port`

## Requirements
- R1: A transfer swaps exactly 8 bits, most significant bit first. The transmitted byte leaves on the output data pin while the received byte enters on the input data pin.
- R2: With `cpol`=0 the idle clock level is low, and with `cpol`=1 it is high. In master mode the master clock idles at `cpol`, and a request for `cphaReq`=1 is overridden: the transfer behaves exactly as with `cphaReq`=0.
- R3: In master mode each clock half period lasts max(`clkDiv`, 6) system cycles, so the full period is never shorter than 12 cycles. `selNOut` is low for all 16 clock edges of the byte and high again when `busy` falls.
- R4: In slave mode all four `cpol`/`cphaReq` combinations work. With phase 0, data is sampled on the leading edge and changed on the trailing edge, and the first bit is already valid when select falls. With phase 1, data is changed on the leading edge and sampled on the trailing edge.
- R5: In master mode pin A and the clock and select outputs are enabled (`pinAOe`, `sckOe`, `selOe` = 1), and pin B is an input. In slave mode pin A is an input, and `pinBOe` is 1 only while the port is selected.
- R6: When a byte completes, it is copied into the read buffer and `rxFull` is set. `rdData` keeps the previous byte while a later byte shifts in. `rxFull` stays set until `rdEn` is pulsed.
- R7: If a byte completes while `rxFull` is still set, `overrun` is set and the buffer keeps the older byte. `rdEn` clears both `rxFull` and `overrun`.
- R8: A write while `busy` is high is ignored: the byte being shifted out does not change, and `wcol` is set. The next accepted write clears `wcol`.
- R9: After reset, `rdData`=0, `rxFull`, `overrun`, `wcol` and `busy` are 0, `selNOut`=1 and `sckOut`=0.
- R10: In slave mode `busy` follows the synchronised select. If select is released in the middle of a byte, the bit count restarts, so the next selected byte is received whole and correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| isMaster | input | 1 | 1 = master role, 0 = slave role |
| cpol | input | 1 | Clock idle level |
| cphaReq | input | 1 | Requested clock phase (forced to 0 in master mode) |
| clkDiv | input | DIV_W | Master half-period length in system cycles (minimum 6 applied) |
| wrEn | input | 1 | Write strobe for the outgoing byte |
| wrData | input | BITS | Outgoing byte |
| rdEn | input | 1 | Read acknowledge; clears rxFull and overrun |
| rdData | output | BITS | Read buffer |
| rxFull | output | 1 | Read buffer holds an unread byte |
| overrun | output | 1 | A byte completed while the buffer was unread |
| wcol | output | 1 | A write was rejected during a transfer |
| busy | output | 1 | Transfer in progress (master) or selected (slave) |
| sckIn | input | 1 | Serial clock from outside (slave) |
| sckOut | output | 1 | Generated serial clock (master) |
| sckOe | output | 1 | Output enable for sckOut |
| selNIn | input | 1 | Active-low select from outside (slave) |
| selNOut | output | 1 | Generated active-low select (master) |
| selOe | output | 1 | Output enable for selNOut |
| pinAIn | input | 1 | Pin A input value (slave data in) |
| pinAOut | output | 1 | Pin A output value (master data out) |
| pinAOe | output | 1 | Pin A output enable |
| pinBIn | input | 1 | Pin B input value (master data in) |
| pinBOut | output | 1 | Pin B output value (slave data out) |
| pinBOe | output | 1 | Pin B output enable |

## Verification
The hardest state to reach from the ports is a write collision in the middle of a byte. It needs a host write to land between clock edges of a running master transfer, while the bench model of the far-end slave keeps answering bit by bit. The master task therefore runs its own cycle loop, follows every clock edge it sees, and fires the colliding write at a chosen cycle inside that loop. In the same loop it reads the read buffer mid-byte. A second hard case is a slave byte cut off after three bits. The bench drives select and the clock slowly enough for the synchronisers, releases select early, and then sends a full byte whose received value exposes any stale bit count.

// File: rtl/spi_duplex_port_pkg.sv
package spi_duplex_port_pkg;
  // strobes from control to datapath, each valid for one system cycle
  typedef struct packed {
    logic load;     // accepted write: fill shift register
    logic sample;   // capture one incoming bit
    logic drive;    // present next outgoing bit
    logic done;     // last bit of the byte captured this cycle
    logic collide;  // write arrived while busy
    logic rdAck;    // host consumed the read buffer
  } ctl_t;
endpackage

// File: rtl/spi_duplex_port_ctrl.sv
module spi_duplex_port_ctrl
  import spi_duplex_port_pkg::*;
#(
  parameter int BITS     = 8,
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             isMaster,
  input  logic             cpol,
  input  logic             cphaReq,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             sckIn,
  input  logic             selNIn,
  input  logic             pinAIn,
  input  logic             pinBIn,
  output ctl_t             ctl,
  output logic             bitIn,
  output logic             busy,
  output logic             sckOut,
  output logic             selNOut
);
  localparam int CNT_W  = $clog2(BITS);
  localparam int EDGES  = 2 * BITS;
  localparam int EDGE_W = $clog2(EDGES);

  // slave-side synchronisers
  logic [2:0] sckSy;
  logic [1:0] selSy, datSy;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSy <= '0;
      selSy <= 2'b11;
      datSy <= '0;
    end else begin
      sckSy <= {sckSy[1:0], sckIn};
      selSy <= {selSy[0], selNIn};
      datSy <= {datSy[0], pinAIn};
    end
  end

  logic slvSel, slvEdge, slvLead, slvTrail;
  assign slvSel   = !selSy[1];
  assign slvEdge  = slvSel && (sckSy[2] != sckSy[1]);
  assign slvLead  = slvEdge && (sckSy[1] != cpol);
  assign slvTrail = slvEdge && (sckSy[1] == cpol);

  // master clock generator
  logic              running;
  logic [DIV_W-1:0]  halfCnt, halfLen;
  logic [EDGE_W-1:0] edgeCnt;
  logic              tick, mLead, mTrail, lastEdge;

  assign halfLen  = (clkDiv < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : clkDiv;
  assign tick     = running && (halfCnt == halfLen - 1'b1);
  assign mLead    = tick && !edgeCnt[0];
  assign mTrail   = tick && edgeCnt[0];
  assign lastEdge = tick && (edgeCnt == EDGE_W'(EDGES - 1));

  logic accept, cphaEff, lead, trail;
  assign busy    = isMaster ? running : slvSel;
  assign accept  = wrEn && !busy;
  assign cphaEff = isMaster ? 1'b0 : cphaReq;
  assign lead    = isMaster ? mLead  : slvLead;
  assign trail   = isMaster ? mTrail : slvTrail;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      halfCnt <= '0;
      edgeCnt <= '0;
      sckOut  <= 1'b0;
      selNOut <= 1'b1;
    end else if (accept && isMaster) begin
      running <= 1'b1;
      halfCnt <= '0;
      edgeCnt <= '0;
      sckOut  <= cpol;
      selNOut <= 1'b0;
    end else if (running) begin
      if (tick) begin
        halfCnt <= '0;
        sckOut  <= ~sckOut;
        edgeCnt <= edgeCnt + 1'b1;
        if (lastEdge) begin
          running <= 1'b0;
          selNOut <= 1'b1;
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end else begin
      sckOut  <= cpol;
      selNOut <= 1'b1;
    end
  end

  // bit counter shared by both roles
  logic [CNT_W-1:0] bitCnt;
  logic             sampleStb;
  assign sampleStb = cphaEff ? trail : lead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (accept || (!isMaster && !slvSel)) bitCnt <= '0;
    else if (sampleStb) begin
      if (bitCnt == CNT_W'(BITS - 1)) bitCnt <= '0;
      else bitCnt <= bitCnt + 1'b1;
    end
  end

  assign bitIn       = isMaster ? pinBIn : datSy[1];
  assign ctl.load    = accept;
  assign ctl.sample  = sampleStb;
  assign ctl.drive   = cphaEff ? lead : trail;
  assign ctl.done    = sampleStb && (bitCnt == CNT_W'(BITS - 1));
  assign ctl.collide = wrEn && busy;
  assign ctl.rdAck   = rdEn;
endmodule

// File: rtl/spi_duplex_port_dp.sv
module spi_duplex_port_dp
  import spi_duplex_port_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctl_t            ctl,
  input  logic [BITS-1:0] wrData,
  input  logic            bitIn,
  output logic            outBit,
  output logic [BITS-1:0] rdData,
  output logic            rxFull,
  output logic            overrun,
  output logic            wcol
);
  logic [BITS-1:0] shiftReg;
  logic            bufFree;
  assign bufFree = !rxFull || ctl.rdAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      outBit   <= 1'b0;
    end else if (ctl.load) begin
      shiftReg <= wrData;
      outBit   <= wrData[BITS-1];
    end else begin
      if (ctl.sample) shiftReg <= {shiftReg[BITS-2:0], bitIn};
      if (ctl.drive)  outBit   <= shiftReg[BITS-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rxFull  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (ctl.rdAck) begin
        rxFull  <= 1'b0;
        overrun <= 1'b0;
      end
      if (ctl.done) begin
        if (bufFree) begin
          rdData <= {shiftReg[BITS-2:0], bitIn};
          rxFull <= 1'b1;
        end else begin
          overrun <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            wcol <= 1'b0;
    else if (ctl.collide) wcol <= 1'b1;
    else if (ctl.load)    wcol <= 1'b0;
  end
endmodule

// File: rtl/spi_duplex_port.sv
module spi_duplex_port
  import spi_duplex_port_pkg::*;
#(
  parameter int BITS     = 8,
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             isMaster,
  input  logic             cpol,
  input  logic             cphaReq,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             wrEn,
  input  logic [BITS-1:0]  wrData,
  input  logic             rdEn,
  output logic [BITS-1:0]  rdData,
  output logic             rxFull,
  output logic             overrun,
  output logic             wcol,
  output logic             busy,
  input  logic             sckIn,
  output logic             sckOut,
  output logic             sckOe,
  input  logic             selNIn,
  output logic             selNOut,
  output logic             selOe,
  input  logic             pinAIn,
  output logic             pinAOut,
  output logic             pinAOe,
  input  logic             pinBIn,
  output logic             pinBOut,
  output logic             pinBOe
);
  ctl_t ctl;
  logic bitIn, outBit;

  spi_duplex_port_ctrl #(.BITS(BITS), .DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_ctrl (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .cpol(cpol), .cphaReq(cphaReq),
    .clkDiv(clkDiv), .wrEn(wrEn), .rdEn(rdEn), .sckIn(sckIn), .selNIn(selNIn),
    .pinAIn(pinAIn), .pinBIn(pinBIn), .ctl(ctl), .bitIn(bitIn), .busy(busy),
    .sckOut(sckOut), .selNOut(selNOut)
  );

  spi_duplex_port_dp #(.BITS(BITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData), .bitIn(bitIn),
    .outBit(outBit), .rdData(rdData), .rxFull(rxFull), .overrun(overrun), .wcol(wcol)
  );

  // pin roles swap with the mode
  assign pinAOut = outBit;
  assign pinBOut = outBit;
  assign pinAOe  = isMaster;
  assign pinBOe  = !isMaster && busy;
  assign sckOe   = isMaster;
  assign selOe   = isMaster;
endmodule

// File: rtl/spi_duplex_port_chk.sv
module spi_duplex_port_chk #(
  parameter int MIN_HALF = 6
) (
  input logic clk,
  input logic rstN,
  input logic isMaster,
  input logic cpol,
  input logic wrEn,
  input logic rdEn,
  input logic busy,
  input logic rxFull,
  input logic overrun,
  input logic wcol,
  input logic sckOut,
  input logic selNOut
);
  logic       prevSck;
  logic [7:0] stableCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSck   <= 1'b0;
      stableCnt <= 8'hFF;
    end else begin
      prevSck <= sckOut;
      if (sckOut != prevSck)    stableCnt <= '0;
      else if (stableCnt != '1) stableCnt <= stableCnt + 1'b1;
    end
  end

  assert_sel_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    isMaster && busy |-> !selNOut);

  assert_half_period_R3: assert property (@(posedge clk) disable iff (!rstN)
    isMaster && busy && (sckOut != prevSck) |-> stableCnt >= 8'(MIN_HALF - 1));

  assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rstN)
    isMaster && !busy && !wrEn |=> sckOut == $past(cpol));

  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxFull && !rdEn |=> rxFull);

  assert_overrun_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> rxFull);

  assert_collide_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && busy |=> wcol);
endmodule

bind spi_duplex_port spi_duplex_port_chk #(.MIN_HALF(MIN_HALF)) u_chk (
  .clk(clk), .rstN(rstN), .isMaster(isMaster), .cpol(cpol), .wrEn(wrEn),
  .rdEn(rdEn), .busy(busy), .rxFull(rxFull), .overrun(overrun), .wcol(wcol),
  .sckOut(sckOut), .selNOut(selNOut)
);

// File: tb/tb_spi_duplex_port.sv
`timescale 1ns/1ps
module tb_spi_duplex_port;
  localparam int H = 8; // slave half period in system cycles

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic isMaster = 1'b1, cpol = 1'b0, cphaReq = 1'b0;
  logic [7:0] clkDiv = 8'd2;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic rxFull, overrun, wcol, busy;
  logic sckIn = 1'b0, selNIn = 1'b1, pinAIn = 1'b0, pinBIn = 1'b0;
  logic sckOut, sckOe, selNOut, selOe, pinAOut, pinAOe, pinBOut, pinBOe;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_duplex_port dut (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .cpol(cpol), .cphaReq(cphaReq),
    .clkDiv(clkDiv), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .rxFull(rxFull), .overrun(overrun), .wcol(wcol), .busy(busy),
    .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe), .selNIn(selNIn), .selNOut(selNOut),
    .selOe(selOe), .pinAIn(pinAIn), .pinAOut(pinAOut), .pinAOe(pinAOe),
    .pinBIn(pinBIn), .pinBOut(pinBOut), .pinBOe(pinBOe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wrEn = 1'b1; wrData = b;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
  endtask

  // bench acts as far-end slave; optional colliding write at cycle collideAt
  task automatic masterXfer(input logic [7:0] tx, input logic [7:0] slv, input int collideAt,
                            output logic [7:0] got, output int half, output int edges,
                            output bit selOk, output logic [7:0] midRd);
    logic prev;
    int k, lastT;
    pinBIn = slv[7];
    wr(tx);
    prev = sckOut; got = '0; half = 0; edges = 0; selOk = 1; k = 6; lastT = 0; midRd = '0;
    for (int c = 0; c < 4000; c++) begin
      if (c == collideAt) begin wrEn = 1'b1; wrData = 8'h11; end
      if (c == collideAt + 1) wrEn = 1'b0;
      if (c == 30) midRd = rdData;
      if (sckOut != prev) begin
        edges++;
        if (edges == 2) half = c - lastT;
        lastT = c;
        if (edges % 2 == 1) got = {got[6:0], pinAOut};
        else if (k >= 0) begin pinBIn = slv[k]; k--; end
        prev = sckOut;
      end
      if (!busy) break;
      if (selNOut) selOk = 0;
      @(negedge clk);
    end
  endtask

  // bench acts as master; nbits < 8 aborts the byte early
  task automatic slaveXfer(input logic cp, input logic ph, input logic [7:0] drv,
                           input int nbits, output logic [7:0] got, output bit rolesOk,
                           output bit busyOk);
    got = '0; rolesOk = 1; busyOk = 1;
    sckIn = cp; selNIn = 1'b0;
    if (!ph) pinAIn = drv[7];
    repeat (H) @(negedge clk);
    if (!busy) busyOk = 0;
    if (!pinBOe || pinAOe || sckOe || selOe) rolesOk = 0;
    for (int i = 7; i > 7 - nbits; i--) begin
      if (!ph) begin
        got[i] = pinBOut;
        sckIn = ~cp; repeat (H) @(negedge clk);
        sckIn = cp; if (i > 0) pinAIn = drv[i-1];
        repeat (H) @(negedge clk);
      end else begin
        sckIn = ~cp; pinAIn = drv[i];
        repeat (H) @(negedge clk);
        got[i] = pinBOut;
        sckIn = cp; repeat (H) @(negedge clk);
      end
    end
    selNIn = 1'b1;
    repeat (H) @(negedge clk);
    if (busy) busyOk = 0;
  endtask

  task automatic testReset();
    check(rdData == 0 && !rxFull && !overrun && !wcol && !busy, "R9 flags", {rxFull, overrun, wcol, busy}, 0);
    check(selNOut == 1'b1 && sckOut == 1'b0, "R9 pins", {selNOut, sckOut}, 2'b10);
  endtask

  task automatic testMasterBasic();
    logic [7:0] got, mid; int half, edges; bit selOk;
    isMaster = 1; cpol = 0; cphaReq = 0; clkDiv = 8'd2;
    repeat (3) @(negedge clk);
    check(pinAOe && !pinBOe && sckOe && selOe, "R5 master roles", {pinAOe, pinBOe, sckOe, selOe}, 4'b1011);
    masterXfer(8'hA5, 8'h3C, -10, got, half, edges, selOk, mid);
    check(got == 8'hA5, "R1 master tx msb first", got, 8'hA5);
    check(rdData == 8'h3C && rxFull, "R6 master rx", rdData, 8'h3C);
    check(half == 6, "R3 half period floor", half, 6);
    check(edges == 16, "R3 edge count", edges, 16);
    check(selOk && selNOut, "R3 select framing", selNOut, 1);
  endtask

  task automatic testMasterCpol1();
    logic [7:0] got, mid; int half, edges; bit selOk;
    rd();
    cpol = 1; cphaReq = 1; clkDiv = 8'd10;
    repeat (3) @(negedge clk);
    check(sckOut == 1'b1, "R2 idle high", sckOut, 1);
    masterXfer(8'h4E, 8'hB1, -10, got, half, edges, selOk, mid);
    check(got == 8'h4E, "R2 phase forced tx", got, 8'h4E);
    check(rdData == 8'hB1, "R2 phase forced rx", rdData, 8'hB1);
    check(half == 10, "R3 programmed half", half, 10);
    check(sckOut == 1'b1, "R2 idle after", sckOut, 1);
  endtask

  task automatic testOverrun();
    logic [7:0] got, mid; int half, edges; bit selOk;
    cpol = 0; cphaReq = 0; clkDiv = 8'd2;
    repeat (3) @(negedge clk);
    masterXfer(8'h12, 8'hEF, -10, got, half, edges, selOk, mid);
    check(overrun && rxFull, "R7 overrun set", {overrun, rxFull}, 2'b11);
    check(rdData == 8'hB1, "R7 old byte kept", rdData, 8'hB1);
    rd();
    @(negedge clk);
    check(!overrun && !rxFull, "R7 read clears", {overrun, rxFull}, 0);
  endtask

  task automatic testCollision();
    logic [7:0] got, mid; int half, edges; bit selOk;
    masterXfer(8'h96, 8'h69, 40, got, half, edges, selOk, mid);
    check(mid == 8'hB1, "R6 buffer held mid byte", mid, 8'hB1);
    check(wcol, "R8 wcol set", wcol, 1);
    check(got == 8'h96, "R8 write ignored", got, 8'h96);
    check(rdData == 8'h69, "R8 rx intact", rdData, 8'h69);
    rd();
    masterXfer(8'h0F, 8'hF0, -10, got, half, edges, selOk, mid);
    check(!wcol, "R8 wcol cleared", wcol, 0);
    check(got == 8'h0F && rdData == 8'hF0, "R1 second pattern", {got, rdData}, 16'h0FF0);
    rd();
  endtask

  task automatic testSlaveModes();
    logic [7:0] got; bit rolesOk, busyOk;
    logic [7:0] txs [4] = '{8'hC3, 8'h5A, 8'h81, 8'h7E};
    logic [7:0] rxs [4] = '{8'h2D, 8'hE4, 8'h1B, 8'h96};
    isMaster = 0;
    for (int m = 0; m < 4; m++) begin
      cpol = m[1]; cphaReq = m[0]; sckIn = m[1];
      repeat (H) @(negedge clk);
      wr(txs[m]);
      slaveXfer(m[1], m[0], rxs[m], 8, got, rolesOk, busyOk);
      check(got == txs[m], $sformatf("R4 slave tx mode%0d", m), got, txs[m]);
      check(rdData == rxs[m] && rxFull, $sformatf("R4 slave rx mode%0d", m), rdData, rxs[m]);
      check(rolesOk, "R5 slave roles", pinBOe, 1);
      check(busyOk, "R10 busy follows select", busy, 0);
      rd();
    end
  endtask

  task automatic testSlaveAbort();
    logic [7:0] got; bit rolesOk, busyOk;
    cpol = 0; cphaReq = 0; sckIn = 0;
    wr(8'hFF);
    slaveXfer(1'b0, 1'b0, 8'h00, 3, got, rolesOk, busyOk);
    check(!rxFull, "R10 partial no byte", rxFull, 0);
    wr(8'h3A);
    slaveXfer(1'b0, 1'b0, 8'hA7, 8, got, rolesOk, busyOk);
    check(rdData == 8'hA7, "R10 restart rx", rdData, 8'hA7);
    check(got == 8'h3A, "R10 restart tx", got, 8'h3A);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMasterBasic();
    testMasterCpol1();
    testOverrun();
    testCollision();
    testSlaveModes();
    testSlaveAbort();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule